// File: doc/BRIEF.md
# Per-Pin Function Multiplexer for an I/O Bank

This block decides, pin by pin, who drives each pad of a bank of general-purpose pins. A pin belongs either to the general-purpose I/O logic or to one of four internal peripheral functions, labelled A to D. Software uses a small register port to hand pins over and to take them back. Hand-over and take-back use write-one strobes. The peripheral that a pin uses comes from a 2-bit code. Its low bit is held in one select register and its high bit in a second select register, and both select registers are read/write.

Each pad gets its output value and its output enable from its owning source through a combinational five-way mux. The block also keeps the pad configuration bits and drives them out to the pad cells: pull-up, pull-down and Schmitt-trigger disable. It applies one interlock between them: enabling a pull-down also switches off the pull-up of the same pin.

Top module: `pinmux_bank`

## Requirements
- R1: After reset, every pin is owned by general-purpose I/O, both select registers are 0 (peripheral A), every pull-up is enabled, every pull-down is disabled and every Schmitt-disable bit is 0.
- R2: A write to offset 0x04 gives every pin whose data bit is 1 to its selected peripheral, so the pin's bit in the ownership status (offset 0x08, 1 = general-purpose) reads 0. Pins whose data bit is 0 keep their ownership.
- R3: A write to offset 0x00 returns every pin whose data bit is 1 to general-purpose I/O (status bit reads 1). Pins whose data bit is 0 keep their ownership.
- R4: Select register 1 (offset 0x70) and select register 2 (offset 0x74) are ordinary read/write registers. A write replaces the whole value and a read returns it.
- R5: A pin owned by a peripheral drives pad_out and pad_oe from the peripheral with code {select2 bit, select1 bit}: 0 = A, 1 = B, 2 = C, 3 = D. That peripheral's output and enable are taken from bit index code*NPINS+pin of periph_out and periph_oe. fn_code bits [2p+1:2p] report the pin's code.
- R6: A pin owned by general-purpose I/O drives pad_out and pad_oe from gpio_out and gpio_oe, whatever its select code is.
- R7: A write to offset 0x64 sets the pull-up of the pins whose data bit is 1. A write to 0x60 clears them. Offset 0x68 reads the pull-up state. Zero data bits change nothing.
- R8: A write to offset 0x94 enables the pull-down of the pins whose data bit is 1 and also disables their pull-up. A write to 0x90 disables those pull-downs. Offset 0x98 reads the pull-down state.
- R9: Offset 0x100 is a read/write register. A 1 in a pin's bit disables that pin's Schmitt trigger, and the register drives schmitt_off.
- R10: The write-only strobe offsets 0x00, 0x04, 0x60, 0x64, 0x90 and 0x94 read as 0.
- R11: The pad path has no register. A change on gpio_out, gpio_oe, periph_out or periph_oe shows on pad_out or pad_oe without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte offset of the register access |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Combinational read data for bus_addr |
| gpio_out | input | NPINS | Output value from general-purpose I/O logic |
| gpio_oe | input | NPINS | Output enable from general-purpose I/O logic |
| periph_out | input | 4*NPINS | Peripheral output values, function f pin p at f*NPINS+p |
| periph_oe | input | 4*NPINS | Peripheral output enables, same layout |
| pad_out | output | NPINS | Output value to each pad |
| pad_oe | output | NPINS | Output enable to each pad |
| owner_gpio | output | NPINS | 1 where the pin is under general-purpose control |
| fn_code | output | 2*NPINS | Selected peripheral code per pin |
| pull_up | output | NPINS | Pull-up enable per pad |
| pull_dn | output | NPINS | Pull-down enable per pad |
| schmitt_off | output | NPINS | Schmitt-trigger disable per pad |

## Verification
The bench builds the block with the default 32 pins and a 12-bit byte address. With 32 pins, the top pin 31 and full-width write masks can be tested. With a 12-bit address, the Schmitt register at 0x100 can be reached next to the lower offsets. Random write masks are aimed at random register offsets so that partial set/clear patterns and pull interlock overlaps come up. Directed cases set every pin to each of the four peripheral codes in turn and change the pad inputs with no clock edge.

// File: rtl/pinmux_pkg.sv
// Shared constants for the per-pin function multiplexer.
// Assumes byte offsets fit in the address width chosen by the top.
package pinmux_pkg;
    localparam int unsigned OFS_GPIO_EN  = 'h000;  // write 1: pin back to GPIO
    localparam int unsigned OFS_PERI_EN  = 'h004;  // write 1: pin to peripheral
    localparam int unsigned OFS_OWN_STAT = 'h008;  // 1 = GPIO owned
    localparam int unsigned OFS_PU_CLR   = 'h060;
    localparam int unsigned OFS_PU_SET   = 'h064;
    localparam int unsigned OFS_PU_STAT  = 'h068;
    localparam int unsigned OFS_SEL1     = 'h070;  // code bit 0
    localparam int unsigned OFS_SEL2     = 'h074;  // code bit 1
    localparam int unsigned OFS_PD_CLR   = 'h090;
    localparam int unsigned OFS_PD_SET   = 'h094;
    localparam int unsigned OFS_PD_STAT  = 'h098;
    localparam int unsigned OFS_SCHMITT  = 'h100;

    typedef enum logic [1:0] {
        FN_A = 2'd0,
        FN_B = 2'd1,
        FN_C = 2'd2,
        FN_D = 2'd3
    } fn_code_t;
endpackage

// File: rtl/pinmux_regs.sv
// Configuration register file for the pin multiplexer.
// Holds ownership, the two select planes, pull-up/down and Schmitt bits.
// Assumes single-cycle writes; reads are combinational on bus_addr.
module pinmux_regs #(
    parameter int NPINS = 32,
    parameter int AW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic [NPINS-1:0] own_gpio,
    output logic [NPINS-1:0] sel_lo,
    output logic [NPINS-1:0] sel_hi,
    output logic [NPINS-1:0] pu_en,
    output logic [NPINS-1:0] pd_en,
    output logic [NPINS-1:0] st_off
);
    import pinmux_pkg::*;

    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

    logic [NPINS-1:0] own_q, sel1_q, sel2_q, pu_q, pd_q, st_q;

    // Register updates: set/clear strobes act only on 1 bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= ALL_ONES;
            sel1_q <= '0;
            sel2_q <= '0;
            pu_q   <= ALL_ONES;
            pd_q   <= '0;
            st_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                AW'(OFS_GPIO_EN): own_q  <= own_q | bus_wdata;
                AW'(OFS_PERI_EN): own_q  <= own_q & ~bus_wdata;
                AW'(OFS_PU_CLR):  pu_q   <= pu_q & ~bus_wdata;
                AW'(OFS_PU_SET):  pu_q   <= pu_q | bus_wdata;
                AW'(OFS_SEL1):    sel1_q <= bus_wdata;
                AW'(OFS_SEL2):    sel2_q <= bus_wdata;
                AW'(OFS_PD_CLR):  pd_q   <= pd_q & ~bus_wdata;
                AW'(OFS_PD_SET): begin
                    pd_q <= pd_q | bus_wdata;
                    pu_q <= pu_q & ~bus_wdata;
                end
                AW'(OFS_SCHMITT): st_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Read mux: status and read/write registers, strobes read as zero
    always_comb begin
        case (bus_addr)
            AW'(OFS_OWN_STAT): bus_rdata = own_q;
            AW'(OFS_PU_STAT):  bus_rdata = pu_q;
            AW'(OFS_SEL1):     bus_rdata = sel1_q;
            AW'(OFS_SEL2):     bus_rdata = sel2_q;
            AW'(OFS_PD_STAT):  bus_rdata = pd_q;
            AW'(OFS_SCHMITT):  bus_rdata = st_q;
            default:           bus_rdata = '0;
        endcase
    end

    assign own_gpio = own_q;
    assign sel_lo   = sel1_q;
    assign sel_hi   = sel2_q;
    assign pu_en    = pu_q;
    assign pd_en    = pd_q;
    assign st_off   = st_q;

    // R2: peripheral hand-over clears the written pins
    p_peri_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_PERI_EN))
        |=> ((own_q & $past(bus_wdata)) == '0));

    // R3: GPIO return sets the written pins
    p_gpio_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_GPIO_EN))
        |=> ((own_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R4: select plane 1 holds unless written at its offset
    p_sel1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == AW'(OFS_SEL1)) |=> $stable(sel1_q));

    // R8: pull-down enable leaves the same pins without pull-up
    p_pd_kills_pu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_PD_SET))
        |=> ((pu_q & $past(bus_wdata)) == '0));

    // R9: Schmitt register holds unless written at its offset
    p_st_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == AW'(OFS_SCHMITT)) |=> $stable(st_q));
endmodule

// File: rtl/pinmux_lane.sv
// One pad lane: five-way source mux for output value and enable.
// Assumes per_o/per_e are indexed by the 2-bit peripheral code.
module pinmux_lane (
    input  logic       own_gpio,
    input  logic [1:0] code,
    input  logic       gpio_o,
    input  logic       gpio_e,
    input  logic [3:0] per_o,
    input  logic [3:0] per_e,
    output logic       pad_o,
    output logic       pad_e
);
    import pinmux_pkg::*;

    // Source select: GPIO owner first, else peripheral by code
    always_comb begin
        if (own_gpio) begin
            pad_o = gpio_o;
            pad_e = gpio_e;
        end else begin
            case (fn_code_t'(code))
                FN_A:    begin pad_o = per_o[0]; pad_e = per_e[0]; end
                FN_B:    begin pad_o = per_o[1]; pad_e = per_e[1]; end
                FN_C:    begin pad_o = per_o[2]; pad_e = per_e[2]; end
                default: begin pad_o = per_o[3]; pad_e = per_e[3]; end
            endcase
        end
    end
endmodule

// File: rtl/pinmux_bank.sv
// Top of the per-pin function multiplexer for one I/O bank.
// Wires the register file to one mux lane per pin and exposes pad config.
// Assumes NPINS <= 32 words on the register port and AW wide enough for 0x100.
module pinmux_bank #(
    parameter int NPINS = 32,
    parameter int AW    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   gpio_out,
    input  logic [NPINS-1:0]   gpio_oe,
    input  logic [4*NPINS-1:0] periph_out,
    input  logic [4*NPINS-1:0] periph_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   owner_gpio,
    output logic [2*NPINS-1:0] fn_code,
    output logic [NPINS-1:0]   pull_up,
    output logic [NPINS-1:0]   pull_dn,
    output logic [NPINS-1:0]   schmitt_off
);
    localparam int NFN = 4;

    logic [NPINS-1:0] sel_lo, sel_hi;

    pinmux_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .own_gpio  (owner_gpio),
        .sel_lo    (sel_lo),
        .sel_hi    (sel_hi),
        .pu_en     (pull_up),
        .pd_en     (pull_dn),
        .st_off    (schmitt_off)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_lane
        logic [NFN-1:0] po, pe;
        // Gather this pin's bit from each peripheral plane
        for (genvar f = 0; f < NFN; f++) begin : g_fn
            assign po[f] = periph_out[f*NPINS+p];
            assign pe[f] = periph_oe[f*NPINS+p];
        end
        assign fn_code[2*p+1:2*p] = {sel_hi[p], sel_lo[p]};

        pinmux_lane u_lane (
            .own_gpio (owner_gpio[p]),
            .code     ({sel_hi[p], sel_lo[p]}),
            .gpio_o   (gpio_out[p]),
            .gpio_e   (gpio_oe[p]),
            .per_o    (po),
            .per_e    (pe),
            .pad_o    (pad_out[p]),
            .pad_e    (pad_oe[p])
        );
    end

    // R6: a GPIO-owned pin mirrors the GPIO source at every clock
    p_gpio_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner_gpio & (pad_out ^ gpio_out)) == '0));
endmodule

// File: tb/sim_pinmux_bank.sv
`timescale 1ns/1ps
module sim_pinmux_bank;
    localparam int NPINS = 32;
    localparam int AW    = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic [NPINS-1:0]   bus_wdata = '0;
    logic [NPINS-1:0]   bus_rdata;
    logic [NPINS-1:0]   gpio_out = '0, gpio_oe = '0;
    logic [4*NPINS-1:0] periph_out = '0, periph_oe = '0;
    logic [NPINS-1:0]   pad_out, pad_oe, owner_gpio, pull_up, pull_dn, schmitt_off;
    logic [2*NPINS-1:0] fn_code;

    int checks = 0;
    int errors = 0;

    // model state
    logic [31:0] m_own, m_s1, m_s2, m_pu, m_pd, m_st;

    always #2 clk = ~clk;

    pinmux_bank #(.NPINS(NPINS), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .owner_gpio(owner_gpio),
        .fn_code(fn_code), .pull_up(pull_up), .pull_dn(pull_dn),
        .schmitt_off(schmitt_off)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pad(input logic [31:0] own, s1, s2, gv,
                                            input logic [127:0] pv);
        logic [31:0] r;
        for (int p = 0; p < 32; p++) begin
            int c;
            c = {s2[p], s1[p]};
            r[p] = own[p] ? gv[p] : pv[c*32+p];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_code(input logic [31:0] s1, s2);
        logic [63:0] r;
        for (int p = 0; p < 32; p++) r[2*p +: 2] = {s2[p], s1[p]};
        return r;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            'h000: m_own = m_own | d;
            'h004: m_own = m_own & ~d;
            'h060: m_pu  = m_pu & ~d;
            'h064: m_pu  = m_pu | d;
            'h070: m_s1  = d;
            'h074: m_s2  = d;
            'h090: m_pd  = m_pd & ~d;
            'h094: begin m_pd = m_pd | d; m_pu = m_pu & ~d; end
            'h100: m_st  = d;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
        bus_addr = AW'(a);
        #0.5;
        check(req, {96'd0, bus_rdata}, {96'd0, exp});
    endtask

    task automatic check_all;
        rd_chk('h008, m_own, "R2/R3 ownership status");
        rd_chk('h070, m_s1, "R4 select1");
        rd_chk('h074, m_s2, "R4 select2");
        rd_chk('h068, m_pu, "R7 pull-up status");
        rd_chk('h098, m_pd, "R8 pull-down status");
        rd_chk('h100, m_st, "R9 schmitt");
        check("R9 schmitt_off port", {96'd0, schmitt_off}, {96'd0, m_st});
        check("R5 fn_code", {64'd0, fn_code}, {64'd0, exp_code(m_s1, m_s2)});
        check("R5/R6 pad_out", {96'd0, pad_out},
              {96'd0, exp_pad(m_own, m_s1, m_s2, gpio_out, periph_out)});
        check("R5/R6 pad_oe", {96'd0, pad_oe},
              {96'd0, exp_pad(m_own, m_s1, m_s2, gpio_oe, periph_oe)});
    endtask

    task automatic new_inputs;
        gpio_out   = $urandom; gpio_oe = $urandom;
        periph_out = {$urandom, $urandom, $urandom, $urandom};
        periph_oe  = {$urandom, $urandom, $urandom, $urandom};
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int addrs[9];
        void'($urandom(32'h5eed_0042));
        addrs = '{'h000, 'h004, 'h060, 'h064, 'h070, 'h074, 'h090, 'h094, 'h100};
        m_own = '1; m_s1 = '0; m_s2 = '0; m_pu = '1; m_pd = '0; m_st = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 owner_gpio", {96'd0, owner_gpio}, {96'd0, 32'hFFFF_FFFF});
        check("R1 pull_up", {96'd0, pull_up}, {96'd0, 32'hFFFF_FFFF});
        check("R1 pull_dn", {96'd0, pull_dn}, 128'd0);
        check("R1 schmitt_off", {96'd0, schmitt_off}, 128'd0);
        check("R1 fn_code", {64'd0, fn_code}, 128'd0);
        check_all;

        // R10 strobe offsets read as zero
        foreach (addrs[i]) if (addrs[i] != 'h070 && addrs[i] != 'h074 && addrs[i] != 'h100)
            rd_chk(addrs[i], 32'd0, "R10 strobe reads zero");

        // R5: all pins to peripheral, sweep each code
        wr('h004, 32'hFFFF_FFFF);
        for (int c = 0; c < 4; c++) begin
            wr('h070, c[0] ? 32'hFFFF_FFFF : 32'd0);
            wr('h074, c[1] ? 32'hFFFF_FFFF : 32'd0);
            new_inputs;
            #0.5;
            check("R5 code sweep pad_out", {96'd0, pad_out}, {96'd0, periph_out[c*32 +: 32]});
            check("R5 code sweep pad_oe", {96'd0, pad_oe}, {96'd0, periph_oe[c*32 +: 32]});
        end

        // R11 combinational path without a clock edge
        @(negedge clk);
        #0.5;
        periph_out[3*32 +: 32] = 32'hA5A5_0F0F;
        #0.2;
        check("R11 pad follows input", {96'd0, pad_out}, {96'd0, 32'hA5A5_0F0F});

        // R3 partial return of pin 31 and pin 0 only
        wr('h000, 32'h8000_0001);
        check("R3 partial return", {96'd0, owner_gpio}, {96'd0, 32'h8000_0001});
        gpio_out = 32'h8000_0000;
        #0.2;
        check("R6 gpio pin 31 ignores select", {127'd0, pad_out[31]}, 128'd1);

        // R8 pull-down interlock on pin 31
        wr('h094, 32'h8000_0000);
        check("R8 interlock pull_up", {127'd0, pull_up[31]}, 128'd0);
        check("R8 pull_dn set", {127'd0, pull_dn[31]}, 128'd1);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            d = $urandom;
            if (n % 3 == 0) d = d & $urandom & $urandom;
            wr(addrs[$urandom % 9], d);
            new_inputs;
            check_all;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule